// File: doc/BRIEF.md
# SPI Master Long-Burst Word Serializer

This block is the shift datapath of an SPI master. It runs a single chip-select burst whose length in bits is set by a programmable length field, and the burst may span several 32-bit words. Transmit words come from a TX FIFO over a valid/ready pair. The block works out how many bits to take from each word, sends them MSB-first on MOSI, and packs the MISO bits it samples into words that it presents to an RX FIFO with a one-cycle valid strobe.

When a burst longer than one word is not a whole multiple of the word width, the leftover bits come from the low end of the first word. Every later word is sent in full. For example, a 48-bit burst sends the low 16 bits of word 0 and then all 32 bits of word 1. Received words follow the same slicing, so a short first RX word is right-justified. Software writes the length as bits minus one. It pulses a start input, feeds words as the FIFO fills, and waits for the done strobe.

SCLK idles low. MOSI changes on the falling edge and MISO is sampled on the rising edge. Each SCLK phase lasts a fixed number of system clocks set by a parameter. If the TX FIFO runs dry between words, SCLK stops low and chip-select stays asserted until the next word arrives.

Top module: `spi_lb_master`

## Requirements
- R1: The length field L gives the burst size as L+1 bits. One start pulse produces exactly L+1 rising SCLK edges before done.
- R2: The first TX word contributes its low n0 bits, where n0 = (L+1) mod 32, or 32 when that remainder is zero. Every later word contributes all 32 bits, so a burst uses ceil((L+1)/32) TX words and no more.
- R3: Within each word the selected slice is sent MSB-first. The first bit on MOSI is bit n-1 of the word, where n is the slice size, and the last is bit 0.
- R4: One RX word is pushed per TX word, at the end of its slice. It holds the n sampled MISO bits right-justified, first sampled bit highest, upper bits zero. rx_valid_o is high for a single cycle per word.
- R5: A burst of 32 bits or fewer takes exactly one TX word and yields exactly one RX word.
- R6: While the block waits for a TX word with tx_valid_i low, SCLK stays low and cs_n_o stays low. The burst still delivers all L+1 bits once data resumes.
- R7: cs_n_o goes low after start and stays low whenever SCLK is high, through the last bit of the burst.
- R8: done_o is a one-cycle pulse in the cycle after the last falling SCLK edge. cs_n_o is high in that cycle and stays high afterwards.
- R9: SCLK idles low, and MOSI does not change while SCLK rises or is high. A rising edge follows the previous rising edge of the same word after 2*HALF_DIV system clocks, and SCLK is low whenever tx_ready_o is high.
- R10: During and after reset, cs_n_o is 1 and sclk_o, tx_ready_o, rx_valid_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a burst (sampled while idle) |
| burst_len_i | input | LEN_W | Burst length in bits minus one |
| tx_data_i | input | WORD_W | TX FIFO word |
| tx_valid_i | input | 1 | TX FIFO has a word |
| tx_ready_o | output | 1 | Block takes the word this cycle |
| rx_data_o | output | WORD_W | Received word, right-justified |
| rx_valid_o | output | 1 | One-cycle push strobe to the RX FIFO |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low chip select |
| done_o | output | 1 | One-cycle end-of-burst strobe |

## Verification
The properties assume start_i is pulsed only while the block is idle. They also assume the RX FIFO can always take a word, because the block has no backpressure on its receive side. The stimulus issues each start only after the previous done and after a few quiet cycles. It drives every input on the falling system clock edge, and it offers TX words only while tx_ready_o is high, including deliberate gaps that hold tx_valid_i low to exercise the stall path.

// File: rtl/spi_lb_pkg.sv
package spi_lb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } lb_state_e;

endpackage

// File: rtl/spi_lb_clkgen.sv
module spi_lb_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic tick;
  logic sclk_q, sclk_d;

  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign tick = run_i;
    end else begin : g_div
      logic [DIV_W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
          cnt_d = '0;
        end else if (cnt_q == DIV_W'(HALF_DIV - 1)) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + DIV_W'(1);
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick = run_i && (cnt_q == DIV_W'(HALF_DIV - 1));
    end
  endgenerate

  always_comb begin
    sclk_d = sclk_q;
    if (!run_i) begin
      sclk_d = 1'b0;
    end else if (tick) begin
      sclk_d = ~sclk_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;

endmodule

// File: rtl/spi_lb_slicer.sv
module spi_lb_slicer #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 6,
  parameter int BITS_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic              word_load_i,
  input  logic              bit_done_i,
  output logic [CNT_W-1:0]  slice_bits_o,
  output logic              last_in_word_o,
  output logic              last_in_burst_o
);

  logic [BITS_W-1:0] bits_left_q, bits_left_d;
  logic [CNT_W-1:0]  word_left_q, word_left_d;
  logic              first_q, first_d;
  logic [BITS_W-1:0] remainder;

  // leftover bits of a burst that is not a whole number of words
  assign remainder = bits_left_q % BITS_W'(WORD_W);

  always_comb begin
    if (first_q && (remainder != '0)) begin
      slice_bits_o = CNT_W'(remainder);
    end else begin
      slice_bits_o = CNT_W'(WORD_W);
    end
  end

  always_comb begin
    bits_left_d = bits_left_q;
    word_left_d = word_left_q;
    first_d     = first_q;
    if (start_i) begin
      bits_left_d = BITS_W'(burst_len_i) + BITS_W'(1);
      word_left_d = '0;
      first_d     = 1'b1;
    end else if (word_load_i) begin
      word_left_d = slice_bits_o;
      first_d     = 1'b0;
    end else if (bit_done_i) begin
      bits_left_d = bits_left_q - BITS_W'(1);
      word_left_d = word_left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_left_q <= '0;
      word_left_q <= '0;
      first_q     <= 1'b0;
    end else begin
      bits_left_q <= bits_left_d;
      word_left_q <= word_left_d;
      first_q     <= first_d;
    end
  end

  assign last_in_word_o  = (word_left_q == CNT_W'(1));
  assign last_in_burst_o = (bits_left_q == BITS_W'(1));

endmodule

// File: rtl/spi_lb_shifter.sv
module spi_lb_shifter #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  slice_bits_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);

  logic [WORD_W-1:0] tx_sr_q, tx_sr_d;
  logic [WORD_W-1:0] rx_sr_q, rx_sr_d;
  logic [CNT_W-1:0]  align;

  // move the slice's top bit up to the MSB of the shift register
  assign align = CNT_W'(WORD_W) - slice_bits_i;

  always_comb begin
    tx_sr_d = tx_sr_q;
    rx_sr_d = rx_sr_q;
    if (load_i) begin
      tx_sr_d = word_i << align;
      rx_sr_d = '0;
    end else begin
      if (shift_i) begin
        tx_sr_d = {tx_sr_q[WORD_W-2:0], 1'b0};
      end
      if (sample_i) begin
        rx_sr_d = {rx_sr_q[WORD_W-2:0], miso_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else begin
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
    end
  end

  assign mosi_o    = tx_sr_q[WORD_W-1];
  assign rx_word_o = rx_sr_q;

endmodule

// File: rtl/spi_lb_master.sv
module spi_lb_master
  import spi_lb_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int LEN_W    = 12,
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o,
  output logic              done_o
);

  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int BITS_W = LEN_W + 1;

  lb_state_e state_q, state_d;

  logic             run;
  logic             rise, fall;
  logic             word_load;
  logic             slicer_start;
  logic [CNT_W-1:0] slice_bits;
  logic             last_in_word, last_in_burst;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] rx_data_q, rx_data_d;
  logic             rx_valid_q, rx_valid_d;
  logic             word_end;

  assign run          = (state_q == ST_SHIFT);
  assign word_load    = (state_q == ST_FETCH) && tx_valid_i;
  assign slicer_start = (state_q == ST_IDLE) && start_i;
  assign word_end     = run && fall && last_in_word;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)    state_d = ST_FETCH;
      ST_FETCH: if (tx_valid_i) state_d = ST_SHIFT;
      ST_SHIFT: if (word_end)   state_d = last_in_burst ? ST_DONE : ST_FETCH;
      ST_DONE:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  spi_lb_clkgen #(
    .HALF_DIV (HALF_DIV)
  ) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_lb_slicer #(
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W),
    .BITS_W (BITS_W)
  ) u_slicer (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (slicer_start),
    .burst_len_i     (burst_len_i),
    .word_load_i     (word_load),
    .bit_done_i      (run && fall),
    .slice_bits_o    (slice_bits),
    .last_in_word_o  (last_in_word),
    .last_in_burst_o (last_in_burst)
  );

  spi_lb_shifter #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
  ) u_shifter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (word_load),
    .word_i       (tx_data_i),
    .slice_bits_i (slice_bits),
    .shift_i      (run && fall),
    .sample_i     (run && rise),
    .miso_i       (miso_i),
    .mosi_o       (mosi_o),
    .rx_word_o    (rx_word)
  );

  // RX push: the last bit was captured on the rise before this fall
  always_comb begin
    rx_valid_d = word_end;
    rx_data_d  = word_end ? rx_word : rx_data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= rx_valid_d;
      rx_data_q  <= rx_data_d;
    end
  end

  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign tx_ready_o = (state_q == ST_FETCH);
  assign cs_n_o     = !((state_q == ST_FETCH) || (state_q == ST_SHIFT));
  assign done_o     = (state_q == ST_DONE);

endmodule

// File: rtl/spi_lb_master_chk.sv
module spi_lb_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_n_o,
  input logic tx_ready_o,
  input logic tx_valid_i,
  input logic rx_valid_o,
  input logic done_o
);

  p_sclk_in_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_n_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_n_o);

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> (tx_ready_o && !sclk_o && !cs_n_o));

  p_mosi_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));

  p_mosi_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_ready_low_sclk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !sclk_o);

  p_rx_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

endmodule

bind spi_lb_master spi_lb_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .cs_n_o     (cs_n_o),
  .tx_ready_o (tx_ready_o),
  .tx_valid_i (tx_valid_i),
  .rx_valid_o (rx_valid_o),
  .done_o     (done_o)
);

// File: tb/spi_lb_master_test.sv
module spi_lb_master_test;

  localparam int WORD_W   = 32;
  localparam int LEN_W    = 12;
  localparam int HALF_DIV = 2;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [31:0]      w0;
    logic [31:0]      w1;
    logic [31:0]      w2;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{12'd0,  32'hFFFF_FFFE, 32'h0,         32'h0},
    '{12'd7,  32'h1234_56A5, 32'h0,         32'h0},
    '{12'd31, 32'hC3A5_0F96, 32'h0,         32'h0},
    '{12'd32, 32'h0000_0001, 32'h8001_7FFE, 32'h0},
    '{12'd33, 32'hFFFF_FFFE, 32'h1357_9BDF, 32'h0},
    '{12'd47, 32'hABCD_5A3C, 32'hDEAD_BEEF, 32'h0},
    '{12'd63, 32'h0F0F_F0F0, 32'h6996_1EE1, 32'h0},
    '{12'd70, 32'hFFFF_FF55, 32'h2468_ACE0, 32'h8421_1248},
    '{12'd95, 32'h7654_3210, 32'h89AB_CDEF, 32'hFEDC_BA98}
  };

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [LEN_W-1:0]  burst_len_i;
  logic [WORD_W-1:0] tx_data_i;
  logic              tx_valid_i;
  logic              tx_ready_o;
  logic [WORD_W-1:0] rx_data_o;
  logic              rx_valid_o;
  logic              sclk_o;
  logic              mosi_o;
  logic              miso_i;
  logic              cs_n_o;
  logic              done_o;

  int tests;
  int fails;

  int       nbits;
  logic     mosi_cap [0:127];
  realtime  t_rise [0:1];

  spi_lb_master #(
    .WORD_W   (WORD_W),
    .LEN_W    (LEN_W),
    .HALF_DIV (HALF_DIV)
  ) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .burst_len_i (burst_len_i),
    .tx_data_i   (tx_data_i),
    .tx_valid_i  (tx_valid_i),
    .tx_ready_o  (tx_ready_o),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .miso_i      (miso_i),
    .cs_n_o      (cs_n_o),
    .done_o      (done_o)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // slave model: answers with the inverse of what it receives
  assign miso_i = ~mosi_o;

  always @(posedge sclk_o) begin
    if (nbits < 128) mosi_cap[nbits] = mosi_o;
    if (nbits < 2) t_rise[nbits] = $realtime;
    nbits = nbits + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] slice_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic run_vec(input vec_t v, input int stall_word, input int stall_len);
    logic [31:0] w [0:2];
    logic [31:0] rx_got [0:3];
    int nb, n0, nw, idx, nrx, done_cnt, stall_cnt, pos, mism;
    bit got_done, stall_bad, extra;
    w[0] = v.w0; w[1] = v.w1; w[2] = v.w2;
    nb = int'(v.len) + 1;
    n0 = (nb % 32 == 0) ? 32 : nb % 32;
    nw = (nb + 31) / 32;
    idx = 0; nrx = 0; done_cnt = 0; stall_cnt = 0;
    got_done = 0; stall_bad = 0; extra = 0;
    nbits = 0;

    @(negedge clk);
    start_i = 1'b1;
    burst_len_i = v.len;
    for (int cyc = 0; cyc < 6000 && !got_done; cyc++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (rx_valid_o) begin
        if (nrx < 4) rx_got[nrx] = rx_data_o;
        nrx++;
      end
      if (done_o) begin
        done_cnt++;
        got_done = 1;
      end
      if (tx_ready_o) begin
        if (idx == stall_word && stall_cnt < stall_len) begin
          tx_valid_i = 1'b0;
          stall_cnt++;
          if (sclk_o || cs_n_o) stall_bad = 1;
        end else if (idx < nw) begin
          tx_valid_i = 1'b1;
          tx_data_i = w[idx];
          idx++;
        end else begin
          tx_valid_i = 1'b0;
          extra = 1;
        end
      end else begin
        tx_valid_i = 1'b0;
      end
    end
    tx_valid_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done_o) done_cnt++;
      if (rx_valid_o) nrx++;
    end

    // R1: bit count
    check(nbits == nb, "R1", $sformatf("SCLK rises len=%0d", v.len), nbits, nb);
    // R2/R5: TX words consumed
    check(idx == nw && !extra, (nw == 1) ? "R5" : "R2", "TX words taken", idx, nw);
    // R2/R3: MOSI bit sequence
    mism = -1;
    pos = 0;
    for (int k = 0; k < nw; k++) begin
      int n;
      n = (k == 0) ? n0 : 32;
      for (int j = n - 1; j >= 0; j--) begin
        if (pos < 128 && pos < nbits && mosi_cap[pos] !== w[k][j] && mism < 0) mism = pos;
        pos++;
      end
    end
    check(mism < 0, "R3", $sformatf("MOSI order len=%0d first bad bit", v.len), mism, -1);
    // R4/R5: RX words
    check(nrx == nw, (nw == 1) ? "R5" : "R4", "RX word count", nrx, nw);
    for (int k = 0; k < nw && k < nrx; k++) begin
      logic [31:0] exp;
      exp = (~w[k]) & slice_mask((k == 0) ? n0 : 32);
      check(rx_got[k] === exp, "R4", $sformatf("RX word %0d len=%0d", k, v.len), rx_got[k], exp);
    end
    // R8: single done, cs released
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(cs_n_o === 1'b1, "R8", "cs_n after done", cs_n_o, 1);
    // R6: stall behaviour
    if (stall_len > 0) begin
      check(!stall_bad && stall_cnt == stall_len, "R6", "SCLK/CS during stall", stall_bad, 0);
    end
    // R9: SCLK period inside a word
    if (n0 >= 2 && nbits >= 2) begin
      check((t_rise[1] - t_rise[0]) == real'(2 * HALF_DIV * 8), "R9", "rise-to-rise ns",
            longint'(t_rise[1] - t_rise[0]), 2 * HALF_DIV * 8);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; nbits = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    burst_len_i = '0;
    tx_data_i = '0;
    tx_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state while held
    check(cs_n_o === 1'b1 && sclk_o === 1'b0 && tx_ready_o === 1'b0 &&
          rx_valid_o === 1'b0 && done_o === 1'b0, "R10", "outputs in reset",
          {cs_n_o, sclk_o, tx_ready_o, rx_valid_o, done_o}, 5'b10000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n_o === 1'b1 && sclk_o === 1'b0 && tx_ready_o === 1'b0 &&
          rx_valid_o === 1'b0 && done_o === 1'b0, "R10", "outputs after reset",
          {cs_n_o, sclk_o, tx_ready_o, rx_valid_o, done_o}, 5'b10000);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i], -1, 0);
      repeat (3) @(negedge clk);
    end

    // R6: stall before the second word of a 48-bit burst
    run_vec(VECS[5], 1, 40);
    repeat (3) @(negedge clk);
    // R6: stall before the first word of a 96-bit burst
    run_vec(VECS[8], 0, 25);
    repeat (3) @(negedge clk);
    // R6/R7: stall before the last word of a 71-bit burst
    run_vec(VECS[7], 2, 17);
    repeat (3) @(negedge clk);
    // R7: cs_n stays high when idle with TX data present
    tx_valid_i = 1'b1;
    tx_data_i = 32'hFFFF_FFFF;
    repeat (10) @(negedge clk);
    check(cs_n_o === 1'b1 && tx_ready_o === 1'b0, "R7", "idle with TX valid",
          {cs_n_o, tx_ready_o}, 2'b10);
    tx_valid_i = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule